// File: doc/BRIEF.md
# Base Instruction Legality Checker

This block screens one 32-bit uncompressed instruction word per cycle and reports whether it is an illegal encoding. It decides from the major opcode, the func3 field, the func7 field, and the encoding of SYSTEM instructions. Build-time switches add the opcode groups for floating point, atomics and 64-bit word operations. A parameter vector lists the CSR addresses the core implements.

The verdict appears one clock after the word is presented. It consists of an illegal flag and a cause code. When more than one check fails, the first failing check in a fixed priority order sets the code. A word whose two low bits are not both one is not a 32-bit encoding, so it is marked "not applicable" and is never flagged. The block is meant to sit beside a decoder or a stimulus generator, as an independent legality oracle.

Top module: `instr_legal_chk`

## Requirements
- R1: Each word accepted with `in_valid` high produces exactly one result with `out_valid` high on the following clock. A synchronous reset clears `out_valid`, `out_illegal`, `out_na` and `out_cause` to zero.
- R2: A word with `in_instr[1:0]` other than 2'b11 gives `out_na`=1, `out_illegal`=0 and `out_cause`=0.
- R3: Opcodes (`in_instr[6:0]`) 0000011, 0001111, 0010011, 0010111, 0100011, 0110011, 0110111, 1100011, 1100111, 1101111 and 1110011 are always accepted. Any other opcode ending in 11 that no enabled group covers gives cause 1 (opcode).
- R4: `EN_FP` adds opcodes 0000111, 0100111, 1000011, 1000111, 1001011, 1001111 and 1010011. `EN_ATOMIC` adds 0101111. `EN_RV64` adds 0011011 and 0111011.
- R5: func3 (`in_instr[14:12]`) gives cause 2 in these cases: opcode 1100111 with func3 not 000; opcode 1100011 with func3 010 or 011; opcode 0001111 with func3 above 001; opcode 1110011 with func3 100.
- R6: Load (0000011) and store (0100011) func3 limits depend on `EN_RV64`. Without it, loads with func3 011 or 111 and stores with func3 011 or above give cause 2. With it, only loads with 111 and stores above 011 give cause 2.
- R7: With `EN_RV64`, opcode 0011011 accepts only func3 000, 001 or 101, and opcode 0111011 rejects func3 010 and 011. Each rejection gives cause 2.
- R8: func7 (`in_instr[31:25]`) is examined only for opcodes 0110011 and 0111011, and for 0010011 with func3 001 or 101. There it must be 0000000, 0100000 or 0000001, or cause 3 results.
- R9: A SYSTEM word (1110011) with func3 000 gives cause 4 in either of two cases. The first is when `in_instr[31:20]` is not one of 0x000, 0x001, 0x002, 0x102, 0x105, 0x302 or 0x7B2. The second is when rs1 (`in_instr[19:15]`) or rd (`in_instr[11:7]`) is nonzero.
- R10: A SYSTEM word with func3 other than 000 and 100 gives cause 4 unless `in_instr[31:20]` equals one of the `NUM_CSR` addresses in `CSR_LIST`.
- R11: The cause codes are 0 none, 1 opcode, 2 func3, 3 func7 and 4 SYSTEM. Opcode outranks func3, func3 outranks func7, and func7 outranks SYSTEM. `out_illegal` is 1 exactly when the cause is nonzero.
- R12: A cycle with `in_valid` low yields `out_valid`, `out_illegal`, `out_na` and `out_cause` all zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word on `in_instr` is to be checked |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Result for the word presented one cycle earlier |
| out_illegal | output | 1 | Word is an illegal encoding |
| out_cause | output | 3 | Cause code: 0 none, 1 opcode, 2 func3, 3 func7, 4 SYSTEM |
| out_na | output | 1 | Word is not a 32-bit encoding |

## Verification
The bench builds two copies of the block side by side. The first, `u_dut`, has every optional group off, which brings the narrow load and store limits and the rejection of the optional opcodes within reach. The second has floating point, atomics and 64-bit enabled, which exposes the wide load and store limits, the word-operation func3 and func7 rules, and the extra opcodes. Both copies use a four-entry CSR list, so CSR addresses that hit and miss the list can both be exercised. An exhaustive sweep of every opcode against every func3 value runs on both copies, followed by directed words for func7, SYSTEM immediates and priority.

// File: rtl/instr_legal_pkg.sv
package instr_legal_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned CSR_AW  = 12;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_OPCODE = 3'd1,
        CAUSE_FUNC3  = 3'd2,
        CAUSE_FUNC7  = 3'd3,
        CAUSE_SYSTEM = 3'd4
    } cause_e;

    typedef struct packed {
        logic   valid;
        logic   illegal;
        cause_e cause;
        logic   na;
    } result_t;

    // major opcodes
    localparam logic [6:0] OPC_LOAD     = 7'b0000011;
    localparam logic [6:0] OPC_FENCE    = 7'b0001111;
    localparam logic [6:0] OPC_ALU_IMM  = 7'b0010011;
    localparam logic [6:0] OPC_AUIPC    = 7'b0010111;
    localparam logic [6:0] OPC_STORE    = 7'b0100011;
    localparam logic [6:0] OPC_ALU_REG  = 7'b0110011;
    localparam logic [6:0] OPC_LUI      = 7'b0110111;
    localparam logic [6:0] OPC_BRANCH   = 7'b1100011;
    localparam logic [6:0] OPC_JALR     = 7'b1100111;
    localparam logic [6:0] OPC_JAL      = 7'b1101111;
    localparam logic [6:0] OPC_SYSTEM   = 7'b1110011;
    localparam logic [6:0] OPC_FP_LOAD  = 7'b0000111;
    localparam logic [6:0] OPC_FP_STORE = 7'b0100111;
    localparam logic [6:0] OPC_FMADD    = 7'b1000011;
    localparam logic [6:0] OPC_FMSUB    = 7'b1000111;
    localparam logic [6:0] OPC_FNMSUB   = 7'b1001011;
    localparam logic [6:0] OPC_FNMADD   = 7'b1001111;
    localparam logic [6:0] OPC_FP_OP    = 7'b1010011;
    localparam logic [6:0] OPC_AMO      = 7'b0101111;
    localparam logic [6:0] OPC_IMM_W    = 7'b0011011;
    localparam logic [6:0] OPC_REG_W    = 7'b0111011;

endpackage

// File: rtl/ilc_opcode_dec.sv
module ilc_opcode_dec
    import instr_legal_pkg::*;
#(
    parameter bit EN_FP     = 1'b0,
    parameter bit EN_ATOMIC = 1'b0,
    parameter bit EN_RV64   = 1'b0
) (
    input  logic [6:0] opcode,
    output logic       legal
);

    always_comb begin
        unique case (opcode)
            OPC_LOAD, OPC_FENCE, OPC_ALU_IMM, OPC_AUIPC, OPC_STORE,
            OPC_ALU_REG, OPC_LUI, OPC_BRANCH, OPC_JALR, OPC_JAL,
            OPC_SYSTEM:
                legal = 1'b1;
            OPC_FP_LOAD, OPC_FP_STORE, OPC_FMADD, OPC_FMSUB,
            OPC_FNMSUB, OPC_FNMADD, OPC_FP_OP:
                legal = EN_FP;
            OPC_AMO:
                legal = EN_ATOMIC;
            OPC_IMM_W, OPC_REG_W:
                legal = EN_RV64;
            default:
                legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/ilc_funct_chk.sv
module ilc_funct_chk
    import instr_legal_pkg::*;
#(
    parameter bit EN_RV64 = 1'b0
) (
    input  logic [6:0] opcode,
    input  logic [2:0] f3,
    input  logic [6:0] f7,
    output logic       f3_bad,
    output logic       f7_bad
);

    logic load_bad;
    logic store_bad;

    // load/store width limits follow the register width
    generate
        if (EN_RV64) begin : g_wide
            assign load_bad  = (f3 == 3'b111);
            assign store_bad = (f3 > 3'b011);
        end else begin : g_narrow
            assign load_bad  = (f3 == 3'b011) || (f3 == 3'b111);
            assign store_bad = (f3 >= 3'b011);
        end
    endgenerate

    always_comb begin
        unique case (opcode)
            OPC_JALR:   f3_bad = (f3 != 3'b000);
            OPC_BRANCH: f3_bad = (f3 == 3'b010) || (f3 == 3'b011);
            OPC_FENCE:  f3_bad = (f3 > 3'b001);
            OPC_LOAD:   f3_bad = load_bad;
            OPC_STORE:  f3_bad = store_bad;
            OPC_SYSTEM: f3_bad = (f3 == 3'b100);
            OPC_IMM_W:  f3_bad = EN_RV64 &&
                                 !((f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b101));
            OPC_REG_W:  f3_bad = EN_RV64 && ((f3 == 3'b010) || (f3 == 3'b011));
            default:    f3_bad = 1'b0;
        endcase
    end

    logic f7_used;
    logic f7_known;

    always_comb begin
        f7_used  = (opcode == OPC_ALU_REG) || (opcode == OPC_REG_W) ||
                   ((opcode == OPC_ALU_IMM) && ((f3 == 3'b001) || (f3 == 3'b101)));
        f7_known = (f7 == 7'b0000000) || (f7 == 7'b0100000) || (f7 == 7'b0000001);
        f7_bad   = f7_used && !f7_known;
    end

endmodule

// File: rtl/ilc_system_chk.sv
module ilc_system_chk
    import instr_legal_pkg::*;
#(
    parameter int unsigned          NUM_CSR  = 4,
    parameter logic [NUM_CSR*12-1:0] CSR_LIST = {12'hC00, 12'h341, 12'h305, 12'h300}
) (
    input  logic [11:0] imm,
    input  logic [4:0]  rs1,
    input  logic [2:0]  f3,
    input  logic [4:0]  rd,
    output logic        sys_bad
);

    logic [NUM_CSR-1:0] csr_hit;

    // one comparator per implemented CSR address
    for (genvar i = 0; i < NUM_CSR; i++) begin : g_csr
        assign csr_hit[i] = (imm == CSR_LIST[i*CSR_AW +: CSR_AW]);
    end

    logic priv_known;

    always_comb begin
        unique case (imm)
            12'h000, 12'h001, 12'h002, 12'h102,
            12'h105, 12'h302, 12'h7B2: priv_known = 1'b1;
            default:                   priv_known = 1'b0;
        endcase
    end

    always_comb begin
        if (f3 == 3'b000) begin
            sys_bad = !priv_known || (rs1 != 5'd0) || (rd != 5'd0);
        end else if (f3 == 3'b100) begin
            sys_bad = 1'b0; // reported by the func3 check
        end else begin
            sys_bad = !(|csr_hit);
        end
    end

endmodule

// File: rtl/instr_legal_chk.sv
module instr_legal_chk
    import instr_legal_pkg::*;
#(
    parameter bit                    EN_FP     = 1'b0,
    parameter bit                    EN_ATOMIC = 1'b0,
    parameter bit                    EN_RV64   = 1'b0,
    parameter int unsigned           NUM_CSR   = 4,
    parameter logic [NUM_CSR*12-1:0] CSR_LIST  = {12'hC00, 12'h341, 12'h305, 12'h300}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_instr,
    output logic        out_valid,
    output logic        out_illegal,
    output logic [2:0]  out_cause,
    output logic        out_na
);

    logic [6:0] opcode;
    logic [2:0] f3;
    logic [6:0] f7;

    assign opcode = in_instr[6:0];
    assign f3     = in_instr[14:12];
    assign f7     = in_instr[31:25];

    logic op_legal;
    logic f3_bad;
    logic f7_bad;
    logic sys_bad;

    ilc_opcode_dec #(
        .EN_FP     (EN_FP),
        .EN_ATOMIC (EN_ATOMIC),
        .EN_RV64   (EN_RV64)
    ) u_opcode (
        .opcode (opcode),
        .legal  (op_legal)
    );

    ilc_funct_chk #(
        .EN_RV64 (EN_RV64)
    ) u_funct (
        .opcode (opcode),
        .f3     (f3),
        .f7     (f7),
        .f3_bad (f3_bad),
        .f7_bad (f7_bad)
    );

    ilc_system_chk #(
        .NUM_CSR  (NUM_CSR),
        .CSR_LIST (CSR_LIST)
    ) u_system (
        .imm     (in_instr[31:20]),
        .rs1     (in_instr[19:15]),
        .f3      (f3),
        .rd      (in_instr[11:7]),
        .sys_bad (sys_bad)
    );

    result_t res_d;
    result_t res_q;

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            if (in_instr[1:0] != 2'b11) begin
                res_d.na = 1'b1;
            end else if (!op_legal) begin
                res_d.cause = CAUSE_OPCODE;
            end else if (f3_bad) begin
                res_d.cause = CAUSE_FUNC3;
            end else if (f7_bad) begin
                res_d.cause = CAUSE_FUNC7;
            end else if ((opcode == OPC_SYSTEM) && sys_bad) begin
                res_d.cause = CAUSE_SYSTEM;
            end
            res_d.illegal = (res_d.cause != CAUSE_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_illegal = res_q.illegal;
    assign out_cause   = res_q.cause;
    assign out_na      = res_q.na;

endmodule

// File: rtl/instr_legal_chk_sva.sv
module instr_legal_chk_sva
    import instr_legal_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [6:0] in_op,
    input logic [2:0] in_f3,
    input logic       out_valid,
    input logic       out_illegal,
    input logic [2:0] out_cause,
    input logic       out_na
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R12
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_illegal && !out_na && (out_cause == 3'd0)));

    // R2
    short_word_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op[1:0] != 2'b11)) |=> (out_na && !out_illegal));

    // R2
    na_no_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_na |-> (out_cause == 3'd0));

    // R3
    unused_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == 7'b0101011)) |=> (out_illegal && (out_cause == CAUSE_OPCODE)));

    // R5
    jalr_func3_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == OPC_JALR) && (in_f3 != 3'b000)) |=>
        (out_illegal && (out_cause == CAUSE_FUNC3)));

endmodule

bind instr_legal_chk instr_legal_chk_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_instr[6:0]),
    .in_f3       (in_instr[14:12]),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_cause   (out_cause),
    .out_na      (out_na)
);

// File: tb/instr_legal_chk_tb.sv
module instr_legal_chk_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [47:0] TB_CSRS = {12'hC00, 12'h341, 12'h305, 12'h300};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;

    logic       b_valid, b_illegal, b_na;
    logic [2:0] b_cause;
    logic       f_valid, f_illegal, f_na;
    logic [2:0] f_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_legal_chk #(
        .EN_FP (1'b0), .EN_ATOMIC (1'b0), .EN_RV64 (1'b0),
        .NUM_CSR (4), .CSR_LIST (TB_CSRS)
    ) u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_instr (in_instr),
        .out_valid (b_valid), .out_illegal (b_illegal),
        .out_cause (b_cause), .out_na (b_na)
    );

    instr_legal_chk #(
        .EN_FP (1'b1), .EN_ATOMIC (1'b1), .EN_RV64 (1'b1),
        .NUM_CSR (4), .CSR_LIST (TB_CSRS)
    ) u_dut_full (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_instr (in_instr),
        .out_valid (f_valid), .out_illegal (f_illegal),
        .out_cause (f_cause), .out_na (f_na)
    );

    typedef struct {
        logic        na;
        logic [2:0]  cause;
        logic [31:0] word;
        string       tag;
    } exp_t;

    exp_t q_b[$];
    exp_t q_f[$];

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    bit armed    = 1'b0;

    // independent model of the requirements, returns {na, cause}
    function automatic logic [3:0] model(logic [31:0] w, bit fp, bit amo, bit w64);
        logic [6:0]  op  = w[6:0];
        logic [2:0]  f3  = w[14:12];
        logic [6:0]  f7  = w[31:25];
        logic [11:0] imm = w[31:20];
        bit ok;
        bit bad3;
        if (op[1:0] != 2'b11) return 4'b1000;
        case (op)
            7'b0000011, 7'b0001111, 7'b0010011, 7'b0010111, 7'b0100011, 7'b0110011,
            7'b0110111, 7'b1100011, 7'b1100111, 7'b1101111, 7'b1110011: ok = 1'b1;
            7'b0000111, 7'b0100111, 7'b1000011, 7'b1000111, 7'b1001011,
            7'b1001111, 7'b1010011: ok = fp;
            7'b0101111: ok = amo;
            7'b0011011, 7'b0111011: ok = w64;
            default: ok = 1'b0;
        endcase
        if (!ok) return 4'd1;
        case (op)
            7'b1100111: bad3 = (f3 != 0);
            7'b1100011: bad3 = (f3 == 2) || (f3 == 3);
            7'b0001111: bad3 = (f3 > 1);
            7'b0000011: bad3 = w64 ? (f3 == 7) : ((f3 == 3) || (f3 == 7));
            7'b0100011: bad3 = w64 ? (f3 > 3) : (f3 >= 3);
            7'b1110011: bad3 = (f3 == 4);
            7'b0011011: bad3 = !((f3 == 0) || (f3 == 1) || (f3 == 5));
            7'b0111011: bad3 = (f3 == 2) || (f3 == 3);
            default:    bad3 = 1'b0;
        endcase
        if (bad3) return 4'd2;
        if ((op == 7'b0110011) || (op == 7'b0111011) ||
            ((op == 7'b0010011) && ((f3 == 1) || (f3 == 5)))) begin
            if (!((f7 == 7'h00) || (f7 == 7'h20) || (f7 == 7'h01))) return 4'd3;
        end
        if (op == 7'b1110011) begin
            if (f3 == 0) begin
                if (!(imm inside {12'h000, 12'h001, 12'h002, 12'h102, 12'h105,
                                  12'h302, 12'h7B2}) ||
                    (w[19:15] != 0) || (w[11:7] != 0)) return 4'd4;
            end else begin
                if (!(imm inside {12'h300, 12'h305, 12'h341, 12'hC00})) return 4'd4;
            end
        end
        return 4'd0;
    endfunction

    function automatic logic [31:0] mk(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] mk_sys(logic [11:0] imm, logic [4:0] rs1,
                                           logic [2:0] f3, logic [4:0] rd);
        return {imm, rs1, f3, rd, 7'b1110011};
    endfunction

    task automatic send(input logic [31:0] w, input string tag);
        exp_t e;
        logic [3:0] r;
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = w;
        e.word = w;
        e.tag  = tag;
        r = model(w, 1'b0, 1'b0, 1'b0);
        e.na = r[3]; e.cause = r[2:0];
        q_b.push_back(e);
        r = model(w, 1'b1, 1'b1, 1'b1);
        e.na = r[3]; e.cause = r[2:0];
        q_f.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_instr = 32'hFFFF_FFFF;
        end
    endtask

    task automatic compare(input string who, input logic na, input logic ill,
                           input logic [2:0] cause, ref exp_t q[$]);
        exp_t e;
        n_checks++;
        if (q.size() == 0) begin
            n_fails++;
            $display("FAIL R1 %s: result with no word pending (actual valid=1, expected none)", who);
        end else begin
            e = q.pop_front();
            if ((na !== e.na) || (cause !== e.cause) || (ill !== (e.cause != 3'd0))) begin
                n_fails++;
                $display("FAIL %s R11 %s word=%h: actual na=%b ill=%b cause=%0d, expected na=%b ill=%b cause=%0d",
                         e.tag, who, e.word, na, ill, cause, e.na, (e.cause != 3'd0), e.cause);
            end
        end
    endtask

    // monitor: results are registered, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && armed && !done) begin
            if (b_valid) compare("base", b_na, b_illegal, b_cause, q_b);
            else if (f_valid) begin
                n_checks++; n_fails++;
                $display("FAIL R1 valid mismatch: actual base=0 full=1, expected equal");
            end
            if (f_valid) compare("full", f_na, f_illegal, f_cause, q_f);
            if (!b_valid && !f_valid) begin
                n_checks++;
                if ((b_illegal | b_na | f_illegal | f_na) !== 1'b0 ||
                    (b_cause | f_cause) !== 3'd0) begin
                    n_fails++;
                    $display("FAIL R12 idle outputs: actual b=%b%b%0d f=%b%b%0d, expected all zero",
                             b_illegal, b_na, b_cause, f_illegal, f_na, f_cause);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset holds outputs low even with a word presented
        in_valid = 1'b1;
        in_instr = mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_checks++;
            if ({b_valid, b_illegal, b_na, b_cause, f_valid, f_illegal, f_na, f_cause} !== '0) begin
                n_fails++;
                $display("FAIL R1 reset state: actual %b, expected 0",
                         {b_valid, b_illegal, b_na, b_cause, f_valid, f_illegal, f_na, f_cause});
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst   = 1'b0;
        armed = 1'b1;
        idle(2);

        // R3 R4 R5 R6 R7 R10: every opcode against every func3
        for (int op = 0; op < 128; op++) begin
            for (int f = 0; f < 8; f++) begin
                send(mk(7'h00, 5'd0, 5'd0, f[2:0], 5'd0, op[6:0]), "R3/R4/R5/R6/R7");
            end
        end
        idle(2);

        // R2: short encodings
        send(32'h0000_4501, "R2");
        send(32'hFFFF_FFFC, "R2");
        send(32'h1234_5672, "R2");

        // R8: func7 field
        send(mk(7'h20, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), "R8");
        send(mk(7'h01, 5'd2, 5'd1, 3'b100, 5'd3, 7'b0110011), "R8");
        send(mk(7'h02, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), "R8");
        send(mk(7'h7F, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0010011), "R8");
        send(mk(7'h04, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0010011), "R8");
        send(mk(7'h20, 5'd2, 5'd1, 3'b101, 5'd3, 7'b0010011), "R8");
        send(mk(7'h03, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0111011), "R8");
        idle(1);

        // R9: privileged immediates and register fields
        send(mk_sys(12'h000, 5'd0, 3'b000, 5'd0), "R9");
        send(mk_sys(12'h105, 5'd0, 3'b000, 5'd0), "R9");
        send(mk_sys(12'h7B2, 5'd0, 3'b000, 5'd0), "R9");
        send(mk_sys(12'h003, 5'd0, 3'b000, 5'd0), "R9");
        send(mk_sys(12'h302, 5'd0, 3'b000, 5'd1), "R9");
        send(mk_sys(12'h302, 5'd4, 3'b000, 5'd0), "R9");

        // R10: CSR address list
        send(mk_sys(12'h300, 5'd1, 3'b001, 5'd2), "R10");
        send(mk_sys(12'hC00, 5'd0, 3'b010, 5'd2), "R10");
        send(mk_sys(12'h341, 5'd3, 3'b111, 5'd2), "R10");
        send(mk_sys(12'h123, 5'd1, 3'b001, 5'd2), "R10");

        // R11: priority between causes
        send(mk(7'h7F, 5'd0, 5'd0, 3'b010, 5'd0, 7'b0111011), "R11");
        send(mk_sys(12'hABC, 5'd1, 3'b100, 5'd1), "R11");
        send(mk(7'h7F, 5'd0, 5'd0, 3'b000, 5'd0, 7'b0101011), "R11");
        send(mk(7'h55, 5'd1, 5'd1, 3'b011, 5'd1, 7'b0000011), "R11");

        // R12: gaps between words
        idle(3);
        send(mk(7'h00, 5'd0, 5'd0, 3'b001, 5'd0, 7'b1100111), "R5");
        idle(1);
        send(mk(7'h00, 5'd0, 5'd0, 3'b011, 5'd0, 7'b0100011), "R6");
        idle(4);

        // R1: every accepted word produced a result
        n_checks++;
        if ((q_b.size() != 0) || (q_f.size() != 0)) begin
            n_fails++;
            $display("FAIL R1 pending results: actual %0d/%0d, expected 0/0", q_b.size(), q_f.size());
        end
        finish_run();
    end

endmodule